// File: doc/BRIEF.md
# AC-link Codec Register Port

This block is the controller end of a serial five-wire audio codec link. It lets a host read and write codec registers. A host places a register index and, for writes, a data word in two command registers. The block sends them in command slots 1 and 2 of the next outgoing 256-bit frame. Every audio slot from 3 upward carries zeros. On the incoming side, the block captures the status address and status data that the codec returns. It also records the codec-ready flag carried in each received tag slot.

A command does not block the host. Completion is reported through sticky flags:
- Two transmit flags mark that the command address and the command data have gone out.
- Two receive flags mark that a status address and status data have arrived.

The host polls these flags. It clears a flag by writing zero to it. For a read, the host compares the returned status address with the index it requested and retries on a mismatch.

The block also drives the codec's cold reset line and a warm-reset wake pulse on the sync line. A link-start bit gates framing. The bit clock comes from the codec. The block samples it in its own clock domain, which must run at least eight times faster.

The register interface is a plain single-cycle select/write strobe with a combinational read mux. It has no back-pressure: every write is taken in the cycle it is strobed.

Top module: `ac97_cmd_port`

## Requirements
- R1: After reset every register reads 0, `ac_reset_n` is 1 and `ac_sync` is 0. Register selects are 0 control, 1 command address, 2 command data, 3 transmit status, 4 receive status.
- R2: A write command (command address bit 19 clear) goes out in the next frame after the command address register is written. The tag slot has bits 15, 14 and 13 set. Slot 1 carries command address bits 19:12. Slot 2 carries command data bits 19:4. All slots are sent MSB first. `ac_sync` is high for the 16 tag bits. Slots 3 to 12 are zero.
- R3: Transmit status bit 31 sets after the last bit of slot 1 of a command frame. Bit 30 sets after the last bit of slot 2 of a write frame.
- R4: Status bits are sticky. A write to a status register ANDs the written value into it, so writing 0 to a bit clears it and writing 1 keeps it.
- R5: A read command (command address bit 19 set) sends a tag with bits 15 and 14 set and bit 13 clear. Slot 1 carries the read bit and the index. Slot 2 is zero. Transmit bit 30 stays clear.
- R6: Control bit 15 follows bit 15 of every received tag slot.
- R7: Received tag bit 14 loads slot 1 bits 19:12 into command address bits 19:12 and sets receive bit 22. Received tag bit 13 loads slot 2 bits 19:4 into command data bits 19:4 and sets receive bit 21.
- R8: Control bit 11 drives `ac_reset_n` low, clears codec ready and halts framing.
- R9: Control bit 10 holds `ac_sync` high while set and for `WARM_MIN_CLKS` clocks after it is cleared.
- R10: While control bit 5 is clear, no frames run: `ac_sync` (outside warm reset) and `ac_sdata_out` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 8x the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| ac_bit_clk | input | 1 | Bit clock from the codec |
| ac_sdata_in | input | 1 | Serial data from the codec |
| ac_sync | output | 1 | Frame sync and warm-reset pulse |
| ac_sdata_out | output | 1 | Serial data to the codec |
| ac_reset_n | output | 1 | Codec cold reset, active low |

## Verification
The hardest case to reach is a read whose reply carries a status address that differs from the requested index. That reply must still land in the command address register and set both receive flags.

The bench contains a bit-accurate codec model. It tracks the frame position from the sync line and answers each scheduled reply in the frame after it is armed. For the last read of the sweep, the model deliberately returns the neighbouring index.

// File: rtl/ac97p_pkg.sv
package ac97p_pkg;
  localparam int NUM_SLOTS = 13;
  localparam int TAG_BITS  = 16;
  localparam int SLOT_BITS = 20;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int BIT_W     = $clog2(SLOT_BITS);

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_CADDR = 3'd1,
    SEL_CDATA = 3'd2,
    SEL_TXST  = 3'd3,
    SEL_RXST  = 3'd4
  } reg_sel_e;

  localparam int B_READY = 15;
  localparam int B_COLD  = 11;
  localparam int B_WARM  = 10;
  localparam int B_START = 5;
  localparam int B_ASENT = 31;
  localparam int B_DSENT = 30;
  localparam int B_SADDR = 22;
  localparam int B_SDATA = 21;
endpackage

// File: rtl/ac97p_edge.sv
module ac97p_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic sdi,
  output logic rise,
  output logic fall,
  output logic sdi_s
);
  logic [2:0] bq;
  logic [1:0] dq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bq <= '0;
      dq <= '0;
    end else begin
      bq <= {bq[1:0], bclk};
      dq <= {dq[0], sdi};
    end
  end

  // the data input travels through the same depth as the clock so it stays aligned
  assign rise  = bq[1] & ~bq[2];
  assign fall  = ~bq[1] & bq[2];
  assign sdi_s = dq[1];
endmodule

// File: rtl/ac97p_framer.sv
module ac97p_framer
  import ac97p_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              link_on,
  input  logic              cmd_pend,
  input  logic [7:0]        cmd_addr,
  input  logic [15:0]       cmd_data,
  output logic [SLOT_W-1:0] slot,
  output logic [BIT_W-1:0]  bitc,
  output logic              sync_q,
  output logic              sdo_q,
  output logic              frame_start,
  output logic              addr_sent,
  output logic              data_sent
);
  logic [SLOT_W-1:0]    slot_q, slot_n;
  logic [BIT_W-1:0]     bit_q, bit_n;
  logic [TAG_BITS-1:0]  tag_q, tag_n;
  logic [SLOT_BITS-1:0] s1_q, s1_n, s2_q, s2_n;
  logic                 f_cmd, f_wr, is_rd, out_bit;

  assign is_rd = cmd_addr[7];

  always_comb begin
    if (bit_q == '0) begin
      slot_n = (slot_q == SLOT_W'(NUM_SLOTS-1)) ? '0 : slot_q + 1'b1;
      bit_n  = (slot_n == '0) ? BIT_W'(TAG_BITS-1) : BIT_W'(SLOT_BITS-1);
    end else begin
      slot_n = slot_q;
      bit_n  = bit_q - 1'b1;
    end
  end

  assign frame_start = rise && link_on && bit_q == '0 && slot_q == SLOT_W'(NUM_SLOTS-1);
  assign addr_sent   = rise && link_on && f_cmd && bit_q == '0 && slot_q == SLOT_W'(1);
  assign data_sent   = rise && link_on && f_wr  && bit_q == '0 && slot_q == SLOT_W'(2);

  always_comb begin
    tag_n = tag_q;
    s1_n  = s1_q;
    s2_n  = s2_q;
    if (frame_start) begin
      tag_n = {cmd_pend, cmd_pend, cmd_pend & ~is_rd, 13'b0};
      s1_n  = cmd_pend ? {cmd_addr, 12'b0} : '0;
      s2_n  = (cmd_pend && !is_rd) ? {cmd_data, 4'b0} : '0;
    end
    case (slot_n)
      SLOT_W'(0): out_bit = tag_n[bit_n[3:0]];
      SLOT_W'(1): out_bit = s1_n[bit_n];
      SLOT_W'(2): out_bit = s2_n[bit_n];
      default:    out_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !link_on) begin
      slot_q <= SLOT_W'(NUM_SLOTS-1);
      bit_q  <= '0;
      sync_q <= 1'b0;
      sdo_q  <= 1'b0;
      f_cmd  <= 1'b0;
      f_wr   <= 1'b0;
      tag_q  <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
    end else if (rise) begin
      slot_q <= slot_n;
      bit_q  <= bit_n;
      sync_q <= (slot_n == '0);
      sdo_q  <= out_bit;
      tag_q  <= tag_n;
      s1_q   <= s1_n;
      s2_q   <= s2_n;
      if (frame_start) begin
        f_cmd <= cmd_pend;
        f_wr  <= cmd_pend & ~is_rd;
      end
    end
  end

  assign slot = slot_q;
  assign bitc = bit_q;
endmodule

// File: rtl/ac97p_deframer.sv
module ac97p_deframer
  import ac97p_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              sdi,
  input  logic              link_on,
  input  logic [SLOT_W-1:0] slot,
  input  logic [BIT_W-1:0]  bitc,
  output logic              rdy_evt,
  output logic              rdy_val,
  output logic              addr_evt,
  output logic              data_evt,
  output logic [15:0]       word_hi
);
  logic [SLOT_BITS-2:0] sh;
  logic [SLOT_BITS-1:0] word;
  logic                 tag_a, tag_d;

  assign word = {sh, sdi};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh       <= '0;
      tag_a    <= 1'b0;
      tag_d    <= 1'b0;
      rdy_evt  <= 1'b0;
      rdy_val  <= 1'b0;
      addr_evt <= 1'b0;
      data_evt <= 1'b0;
      word_hi  <= '0;
    end else begin
      rdy_evt  <= 1'b0;
      addr_evt <= 1'b0;
      data_evt <= 1'b0;
      if (fall && link_on) begin
        sh <= word[SLOT_BITS-2:0];
        if (bitc == '0) begin
          word_hi <= word[19:4];
          case (slot)
            SLOT_W'(0): begin
              tag_a   <= word[14];
              tag_d   <= word[13];
              rdy_evt <= 1'b1;
              rdy_val <= word[15];
            end
            SLOT_W'(1): addr_evt <= tag_a;
            SLOT_W'(2): data_evt <= tag_d;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ac97_cmd_port.sv
module ac97_cmd_port
  import ac97p_pkg::*;
#(
  parameter int WARM_MIN_CLKS = 250
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ac_bit_clk,
  input  logic        ac_sdata_in,
  output logic        ac_sync,
  output logic        ac_sdata_out,
  output logic        ac_reset_n
);
  localparam int WCNT_W = $clog2(WARM_MIN_CLKS + 1);

  logic              rise, fall, sdi_s;
  logic              rdy_q, cold_q, warm_q, start_q, cmd_pend;
  logic [7:0]        caddr_q;
  logic [15:0]       cdata_q;
  logic [1:0]        txst_q, rxst_q;
  logic [WCNT_W-1:0] warm_cnt;
  logic              warm_active, link_on;
  logic [SLOT_W-1:0] slot;
  logic [BIT_W-1:0]  bitc;
  logic              sync_q, frame_start, addr_sent, data_sent;
  logic              rdy_evt, rdy_val, addr_evt, data_evt;
  logic [15:0]       word_hi;
  logic              wr_ctrl, wr_caddr, wr_cdata, wr_tx, wr_rx;
  logic              wdata_unused;

  assign wdata_unused = ^{reg_wdata[29:23], reg_wdata[20], reg_wdata[3:0]};

  assign wr_ctrl  = reg_wr && reg_sel == SEL_CTRL;
  assign wr_caddr = reg_wr && reg_sel == SEL_CADDR;
  assign wr_cdata = reg_wr && reg_sel == SEL_CDATA;
  assign wr_tx    = reg_wr && reg_sel == SEL_TXST;
  assign wr_rx    = reg_wr && reg_sel == SEL_RXST;

  assign warm_active = warm_q || warm_cnt != '0;
  assign link_on     = start_q && !cold_q && !warm_active;

  ac97p_edge u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(ac_bit_clk), .sdi(ac_sdata_in),
    .rise(rise), .fall(fall), .sdi_s(sdi_s)
  );

  ac97p_framer u_framer (
    .clk(clk), .rst_n(rst_n), .rise(rise), .link_on(link_on),
    .cmd_pend(cmd_pend), .cmd_addr(caddr_q), .cmd_data(cdata_q),
    .slot(slot), .bitc(bitc), .sync_q(sync_q), .sdo_q(ac_sdata_out),
    .frame_start(frame_start), .addr_sent(addr_sent), .data_sent(data_sent)
  );

  ac97p_deframer u_deframer (
    .clk(clk), .rst_n(rst_n), .fall(fall), .sdi(sdi_s), .link_on(link_on),
    .slot(slot), .bitc(bitc), .rdy_evt(rdy_evt), .rdy_val(rdy_val),
    .addr_evt(addr_evt), .data_evt(data_evt), .word_hi(word_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q    <= 1'b0;
      cold_q   <= 1'b0;
      warm_q   <= 1'b0;
      start_q  <= 1'b0;
      cmd_pend <= 1'b0;
      caddr_q  <= '0;
      cdata_q  <= '0;
      txst_q   <= '0;
      rxst_q   <= '0;
      warm_cnt <= '0;
    end else begin
      if (wr_ctrl) begin
        cold_q  <= reg_wdata[B_COLD];
        warm_q  <= reg_wdata[B_WARM];
        start_q <= reg_wdata[B_START];
      end
      if (warm_q)              warm_cnt <= WCNT_W'(WARM_MIN_CLKS);
      else if (warm_cnt != '0) warm_cnt <= warm_cnt - 1'b1;

      if (cold_q)       rdy_q <= 1'b0;
      else if (rdy_evt) rdy_q <= rdy_val;

      if (wr_caddr)      caddr_q <= reg_wdata[19:12];
      else if (addr_evt) caddr_q <= word_hi[15:8];
      if (wr_cdata)      cdata_q <= reg_wdata[19:4];
      else if (data_evt) cdata_q <= word_hi;

      if (wr_caddr)         cmd_pend <= 1'b1;
      else if (frame_start) cmd_pend <= 1'b0;

      txst_q <= (txst_q & (wr_tx ? {reg_wdata[B_ASENT], reg_wdata[B_DSENT]} : 2'b11))
              | {addr_sent, data_sent};
      rxst_q <= (rxst_q & (wr_rx ? {reg_wdata[B_SADDR], reg_wdata[B_SDATA]} : 2'b11))
              | {addr_evt, data_evt};
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[B_READY] = rdy_q;
        reg_rdata[B_COLD]  = cold_q;
        reg_rdata[B_WARM]  = warm_q;
        reg_rdata[B_START] = start_q;
      end
      SEL_CADDR: reg_rdata[19:12] = caddr_q;
      SEL_CDATA: reg_rdata[19:4]  = cdata_q;
      SEL_TXST:  {reg_rdata[B_ASENT], reg_rdata[B_DSENT]} = txst_q;
      SEL_RXST:  {reg_rdata[B_SADDR], reg_rdata[B_SDATA]} = rxst_q;
      default: ;
    endcase
  end

  assign ac_sync    = sync_q | warm_active;
  assign ac_reset_n = ~cold_q;
endmodule

// File: rtl/ac97p_chk.sv
module ac97p_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  reg_sel,
  input logic        reg_wr,
  input logic [31:0] reg_wdata,
  input logic        ac_sync,
  input logic        ac_sdata_out,
  input logic        ac_reset_n,
  input logic        link_on,
  input logic        rdy_q,
  input logic [1:0]  txst_q,
  input logic [1:0]  rxst_q
);
  logic cold_wr, warm_wr, tx_clr31, rx_clr22;
  assign cold_wr  = reg_wr && reg_sel == 3'd0 && reg_wdata[11];
  assign warm_wr  = reg_wr && reg_sel == 3'd0 && reg_wdata[10];
  assign tx_clr31 = reg_wr && reg_sel == 3'd3 && !reg_wdata[31];
  assign rx_clr22 = reg_wr && reg_sel == 3'd4 && !reg_wdata[22];

  AST_COLD_DRIVES_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    cold_wr |=> !ac_reset_n); // R8
  AST_COLD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cold_wr |=> ##1 !rdy_q); // R8
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !link_on |=> !ac_sdata_out); // R10
  AST_WARM_RAISES_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    warm_wr |=> ac_sync); // R9
  AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (txst_q[1] && !tx_clr31) |=> txst_q[1]); // R4
  AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rxst_q[1] && !rx_clr22) |=> rxst_q[1]); // R4
endmodule

bind ac97_cmd_port ac97p_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .ac_sync(ac_sync), .ac_sdata_out(ac_sdata_out),
  .ac_reset_n(ac_reset_n), .link_on(link_on), .rdy_q(rdy_q),
  .txst_q(txst_q), .rxst_q(rxst_q)
);

// File: tb/tb_ac97_cmd_port.sv
module tb_ac97_cmd_port;
  localparam int WARM = 250;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  reg_sel = 0;
  logic        reg_wr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        bclk = 0, sdi = 0;
  logic        ac_sync, ac_sdata_out, ac_reset_n;

  int checks = 0, errors = 0, cycles = 0;

  ac97_cmd_port #(.WARM_MIN_CLKS(WARM)) dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ac_bit_clk(bclk),
    .ac_sdata_in(sdi), .ac_sync(ac_sync), .ac_sdata_out(ac_sdata_out),
    .ac_reset_n(ac_reset_n)
  );

  always #2 clk = ~clk;

  always begin
    repeat (4) @(negedge clk);
    bclk = ~bclk;
  end

  // codec model state written by the stimulus
  logic        codec_rdy = 0;
  logic [6:0]  resp_addr = 0;
  logic [15:0] resp_data = 0;
  int          resp_seq = 0;
  // frame observer and codec driver
  int          resp_done = 0;
  int          pos = 1000;
  logic        prev_sync = 0;
  logic [15:0] c_tag, cur_tag, last_tag;
  logic [19:0] c_s1, c_s2, cur_s1, cur_s2, last_s1, last_s2;
  logic        cur_rest, last_rest;
  int          frames = 0;

  always @(negedge bclk) begin
    if (ac_sync && !prev_sync) pos = 0;
    else if (pos < 1000) pos = pos + 1;
    prev_sync = ac_sync;
    if (pos == 0) begin
      logic rv;
      rv = (resp_seq != resp_done);
      resp_done = resp_seq;
      c_tag = {codec_rdy, rv, rv, 13'b0};
      c_s1  = rv ? {1'b0, resp_addr, 12'b0} : 20'b0;
      c_s2  = rv ? {resp_data, 4'b0} : 20'b0;
      cur_rest = 0;
    end
    if (pos < 16)       sdi = c_tag[15-pos];
    else if (pos < 36)  sdi = c_s1[35-pos];
    else if (pos < 56)  sdi = c_s2[55-pos];
    else                sdi = 1'b0;
    if (pos < 16)       cur_tag[15-pos] = ac_sdata_out;
    else if (pos < 36)  cur_s1[35-pos]  = ac_sdata_out;
    else if (pos < 56)  cur_s2[55-pos]  = ac_sdata_out;
    else if (pos < 256) cur_rest = cur_rest | ac_sdata_out;
    if (pos == 255) begin
      last_tag = cur_tag; last_s1 = cur_s1; last_s2 = cur_s2; last_rest = cur_rest;
      frames = frames + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_frames(input int n);
    int f0;
    f0 = frames;
    while (frames < f0 + n) @(negedge clk);
  endtask

  task automatic wait_bits(input logic [2:0] s, input logic [31:0] m);
    logic [31:0] v;
    for (int t = 0; t < 20000; t++) begin
      rd(s, v);
      if ((v & m) == m) return;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      rd(3'(s), v);
      chk(v == 0, "R1 reg zero", v, 0);
    end
    chk(ac_reset_n == 1 && ac_sync == 0, "R1 pins", {ac_reset_n, ac_sync}, 32'h2);
    // R10 idle link, no frames
    repeat (100) @(negedge clk);
    chk(ac_sync == 0 && ac_sdata_out == 0 && frames == 0, "R10 idle", frames, 0);

    // R8 cold reset pin
    wr(0, 32'h800);
    @(negedge clk);
    chk(ac_reset_n == 0, "R8 cold asserted", ac_reset_n, 0);
    wr(0, 0);
    @(negedge clk);
    chk(ac_reset_n == 1, "R8 cold released", ac_reset_n, 1);

    // R9 warm reset minimum width
    wr(0, 32'h400);
    repeat (3) @(negedge clk);
    chk(ac_sync == 1, "R9 warm high", ac_sync, 1);
    wr(0, 0);
    repeat (WARM - 20) @(negedge clk);
    chk(ac_sync == 1, "R9 warm hold", ac_sync, 1);
    repeat (40) @(negedge clk);
    chk(ac_sync == 0, "R9 warm end", ac_sync, 0);

    // start link, R6 ready reporting
    codec_rdy = 1;
    wr(0, 32'h20);
    wait_frames(3);
    rd(0, v);
    chk(v[15] == 1, "R6 ready set", v, 32'h8020);
    chk(last_tag == 0 && last_rest == 0, "R2 idle frame", last_tag, 0);

    // write sweep: R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      logic [6:0]  idx;
      logic [15:0] dat;
      int f0;
      idx = 7'((i * 23 + 5) & 7'h7f);
      dat = 16'((i * 16'h3B07) ^ 16'hC35A);
      wr(2, {12'b0, dat, 4'b0});
      wr(1, {12'b0, 1'b0, idx, 12'b0});
      wait_bits(3, 32'hC000_0000);
      f0 = frames;
      rd(3, v);
      chk(v == 32'hC000_0000, "R3 both sent", v, 32'hC000_0000);
      while (frames == f0) @(negedge clk);
      chk(last_tag == 16'hE000, "R2 write tag", last_tag, 32'hE000);
      chk(last_s1 == {1'b0, idx, 12'b0}, "R2 slot1", last_s1, {1'b0, idx, 12'b0});
      chk(last_s2 == {dat, 4'b0}, "R2 slot2", last_s2, {dat, 4'b0});
      chk(last_rest == 0, "R2 high slots zero", last_rest, 0);
      if (i == 0) begin
        wr(3, 32'h8000_0000);
        rd(3, v);
        chk(v == 32'h8000_0000, "R4 partial clear", v, 32'h8000_0000);
      end
      wr(3, 0);
      rd(3, v);
      chk(v == 0, "R4 clear tx", v, 0);
    end

    // read sweep: R5 R7, last one has mismatching reply address
    for (int i = 0; i < 6; i++) begin
      logic [6:0]  idx, ra;
      logic [15:0] rdv;
      int f0;
      idx = 7'((i * 37 + 2) & 7'h7f);
      ra  = (i == 5) ? (idx ^ 7'h01) : idx;
      rdv = 16'((i * 16'h1357) ^ 16'hA5A5);
      resp_addr = ra; resp_data = rdv;
      wr(1, {12'b0, 1'b1, idx, 12'b0});
      resp_seq = resp_seq + 1;
      wait_bits(3, 32'h8000_0000);
      f0 = frames;
      while (frames == f0) @(negedge clk);
      chk(last_tag == 16'hC000, "R5 read tag", last_tag, 32'hC000);
      chk(last_s1 == {1'b1, idx, 12'b0}, "R5 read slot1", last_s1, {1'b1, idx, 12'b0});
      chk(last_s2 == 0, "R5 read slot2 zero", last_s2, 0);
      rd(3, v);
      chk(v == 32'h8000_0000, "R5 data flag clear", v, 32'h8000_0000);
      wait_bits(4, 32'h0060_0000);
      rd(4, v);
      chk(v == 32'h0060_0000, "R7 rx flags", v, 32'h0060_0000);
      rd(1, v);
      chk(v[18:12] == ra, "R7 status addr", v[18:12], ra);
      rd(2, v);
      chk(v[19:4] == rdv, "R7 status data", v[19:4], rdv);
      wr(4, 32'h0040_0000);
      rd(4, v);
      chk(v == 32'h0040_0000, "R4 rx partial clear", v, 32'h0040_0000);
      wr(4, 0);
      wr(3, 0);
      rd(4, v);
      chk(v == 0, "R4 clear rx", v, 0);
    end

    // R6 ready follows codec
    codec_rdy = 0;
    wait_frames(2);
    rd(0, v);
    chk(v[15] == 0, "R6 ready dropped", v, 32'h20);
    codec_rdy = 1;
    wait_frames(2);
    rd(0, v);
    chk(v[15] == 1, "R6 ready back", v, 32'h8020);

    // R8 cold reset while running
    wr(0, 32'h820);
    repeat (3) @(negedge clk);
    rd(0, v);
    chk(v[15] == 0, "R8 ready cleared", v, 32'h820);
    repeat (200) @(negedge clk);
    chk(ac_sync == 0 && ac_reset_n == 0, "R8 framing halted", {ac_sync, ac_reset_n}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule